// File: doc/BRIEF.md
# CCD pixel readout timing sequencer

This block produces, for every pixel of a CCD readout, the timed control lines that a host would otherwise have to toggle itself. A pixel cycle opens with a pulse that pre-charges the output node. A settling gap follows while the line falls to its reference level. A short clamp pulse then pins that reference level. Next comes a pulse that moves the charge packet into the output node, and a second settling gap while the video level forms. The cycle closes with a one-cycle strobe that starts the analog-to-digital converter and a wait that covers the conversion time. The cycle then repeats for the next pixel.

A run is started with a single `start` pulse. All durations and the pixel count are sampled at that instant, so the host may change its inputs freely while the run is in progress. `busy` is high for the whole run. `done` pulses for one cycle when the last pixel's conversion wait has ended.

Top module: `ccd_pixel_seq`

## Requirements
- R1: After reset, reset_pulse, clamp_pulse, xfer_pulse, conv_start, busy and done are all low.
- R2: When start is seen high with the block idle, reset_pulse goes high in the following cycle for T_rst cycles, where T_rst is t_reset as sampled at start.
- R3: After the reset pulse, all four control lines stay low for T_ref cycles. clamp_pulse is then high for T_clamp cycles.
- R4: xfer_pulse rises in the cycle right after clamp_pulse falls and stays high for T_xfer cycles.
- R5: After the transfer pulse, all control lines stay low for T_vid cycles. conv_start is then high for exactly one cycle.
- R6: After the conversion strobe, all control lines stay low for T_conv cycles before the next pixel's reset pulse. A pixel therefore lasts T_rst+T_ref+T_clamp+T_xfer+T_vid+1+T_conv cycles.
- R7: A run covers N pixels, where N is pixel_count sampled at start. busy is high from the cycle after start through the last conversion wait. done is high for exactly the next cycle, with busy low in that cycle.
- R8: While busy, start is ignored, and changes on pixel_count and the timing inputs have no effect on the run in progress.
- R9: A timing input or a pixel_count of 0 is treated as 1.
- R10: At most one of reset_pulse, clamp_pulse, xfer_pulse and conv_start is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when idle |
| pixel_count | input | PIX_W | Pixels per run |
| t_reset | input | CNT_W | Reset pulse width in cycles |
| t_ref | input | CNT_W | Reference settle time in cycles |
| t_clamp | input | CNT_W | Clamp pulse width in cycles |
| t_xfer | input | CNT_W | Transfer pulse width in cycles |
| t_video | input | CNT_W | Video settle time in cycles |
| t_conv | input | CNT_W | Conversion wait after the strobe, in cycles |
| reset_pulse | output | 1 | Output-node pre-charge control |
| clamp_pulse | output | 1 | Clamp switch control |
| xfer_pulse | output | 1 | Charge transfer control |
| conv_start | output | 1 | Converter start strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A wrong phase counter stretches or shortens one pulse or gap. That error shows on the control lines within the first pixel, and it shifts every later edge of the run. A wrong state transition swaps or skips a pulse in the first pixel. A fault in the pixel counter or in the sampled settings does not appear until the end of the run: `done` comes early or late, or later pixels run with different timing. The bench therefore compares every cycle of whole runs against a waveform it computes from the sampled settings. While the run is in progress it disturbs start and the settings.

// File: rtl/ccd_pixel_seq.sv
module ccd_pixel_seq #(
  parameter int CNT_W = 8,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PIX_W-1:0] pixel_count,
  input  logic [CNT_W-1:0] t_reset,
  input  logic [CNT_W-1:0] t_ref,
  input  logic [CNT_W-1:0] t_clamp,
  input  logic [CNT_W-1:0] t_xfer,
  input  logic [CNT_W-1:0] t_video,
  input  logic [CNT_W-1:0] t_conv,
  output logic             reset_pulse,
  output logic             clamp_pulse,
  output logic             xfer_pulse,
  output logic             conv_start,
  output logic             busy,
  output logic             done
);

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_REF, S_CLMP, S_XFR, S_VID, S_CNV, S_WAIT
  } phase_t;

  phase_t           state;
  logic [CNT_W-1:0] cnt;
  logic [PIX_W-1:0] pix_left;
  logic [CNT_W-1:0] c_rst, c_ref, c_clmp, c_xfr, c_vid, c_conv;

  function automatic logic [CNT_W-1:0] load(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign reset_pulse = (state == S_RST);
  assign clamp_pulse = (state == S_CLMP);
  assign xfer_pulse  = (state == S_XFR);
  assign conv_start  = (state == S_CNV);
  assign busy        = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      pix_left <= '0;
      done     <= 1'b0;
      c_rst    <= '0;
      c_ref    <= '0;
      c_clmp   <= '0;
      c_xfr    <= '0;
      c_vid    <= '0;
      c_conv   <= '0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          c_rst    <= load(t_reset);
          c_ref    <= load(t_ref);
          c_clmp   <= load(t_clamp);
          c_xfr    <= load(t_xfer);
          c_vid    <= load(t_video);
          c_conv   <= load(t_conv);
          pix_left <= (pixel_count == '0) ? '0 : pixel_count - 1'b1;
          cnt      <= load(t_reset);
          state    <= S_RST;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        unique case (state)
          S_RST:  begin state <= S_REF;  cnt <= c_ref;  end
          S_REF:  begin state <= S_CLMP; cnt <= c_clmp; end
          S_CLMP: begin state <= S_XFR;  cnt <= c_xfr;  end
          S_XFR:  begin state <= S_VID;  cnt <= c_vid;  end
          S_VID:  begin state <= S_CNV;  cnt <= '0;     end
          S_CNV:  begin state <= S_WAIT; cnt <= c_conv; end
          S_WAIT: begin
            if (pix_left == '0) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              pix_left <= pix_left - 1'b1;
              state    <= S_RST;
              cnt      <= c_rst;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_reset_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> reset_pulse);

  assert_clamp_after_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_pulse) |-> ($past(busy) && !$past(reset_pulse)));

  assert_xfer_after_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_pulse) |-> $past(clamp_pulse));

  assert_conv_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (!conv_start && !reset_pulse && busy));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_done_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reset_pulse, clamp_pulse, xfer_pulse, conv_start}));

endmodule

// File: tb/test_ccd_pixel_seq.sv
module test_ccd_pixel_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int PW = 8;

  logic clk = 0, rst_n = 0, start = 0;
  logic [PW-1:0] pixel_count = 0;
  logic [CW-1:0] t_reset = 0, t_ref = 0, t_clamp = 0, t_xfer = 0, t_video = 0, t_conv = 0;
  logic reset_pulse, clamp_pulse, xfer_pulse, conv_start, busy, done;

  int total = 0, bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_pixel_seq #(.CNT_W(CW), .PIX_W(PW)) i_ccd_pixel_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pixel_count(pixel_count),
    .t_reset(t_reset), .t_ref(t_ref), .t_clamp(t_clamp), .t_xfer(t_xfer),
    .t_video(t_video), .t_conv(t_conv),
    .reset_pulse(reset_pulse), .clamp_pulse(clamp_pulse), .xfer_pulse(xfer_pulse),
    .conv_start(conv_start), .busy(busy), .done(done));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int e1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic run(int n, int r, int f, int c, int x, int v, int w);
    int er, ef, ec, ex, ev, ew, en, p, len;
    int err, ovl;
    string tag;
    logic [5:0] act, exp_v;
    er = e1(r); ef = e1(f); ec = e1(c); ex = e1(x); ev = e1(v); ew = e1(w); en = e1(n);
    p = er + ef + ec + ex + ev + 1 + ew;
    len = en * p;
    err = 0; ovl = 0; tag = "";
    act = 0; exp_v = 0;
    @(negedge clk);
    pixel_count = n[PW-1:0]; t_reset = r[CW-1:0]; t_ref = f[CW-1:0]; t_clamp = c[CW-1:0];
    t_xfer = x[CW-1:0]; t_video = v[CW-1:0]; t_conv = w[CW-1:0];
    start = 1;
    for (int k = 1; k <= len + 2; k++) begin
      int q;
      @(negedge clk);
      exp_v = 0;
      if (k <= len) begin
        q = (k - 1) % p;
        exp_v[5] = (q < er);
        exp_v[4] = (q >= er + ef) && (q < er + ef + ec);
        exp_v[3] = (q >= er + ef + ec) && (q < er + ef + ec + ex);
        exp_v[2] = (q == er + ef + ec + ex + ev);
        exp_v[1] = 1;
      end else if (k == len + 1) begin
        exp_v[0] = 1;
      end
      act = {reset_pulse, clamp_pulse, xfer_pulse, conv_start, busy, done};
      if ($countones(act[5:2]) > 1) ovl++;
      if (act != exp_v && err == 0) begin
        err = 1;
        if (act[5] != exp_v[5]) tag = "R2";
        else if (act[4] != exp_v[4]) tag = "R3";
        else if (act[3] != exp_v[3]) tag = "R4";
        else if (act[2] != exp_v[2]) tag = "R5/R6";
        else tag = "R7";
        $display("FAIL %s/R8/R9 n=%0d t=%0d,%0d,%0d,%0d,%0d,%0d cycle %0d: actual=%b expected=%b",
                 tag, n, r, f, c, x, v, w, k, act, exp_v);
      end
      if (k == 1) begin
        start = 0;
        pixel_count = 7; t_reset = 9; t_ref = 0; t_clamp = 5; t_xfer = 0; t_video = 6; t_conv = 2;
      end
      if (k == 2) start = 1;
      if (k == 3) start = 0;
    end
    total++;
    if (err) bad++;
    total++;
    if (ovl != 0) begin
      bad++;
      $display("FAIL R10 overlap cycles: actual=%0d expected=0", ovl);
    end
  endtask

  initial begin
    int s;
    repeat (3) @(negedge clk);
    total++;
    if ({reset_pulse, clamp_pulse, xfer_pulse, conv_start, busy, done} != 0) begin
      bad++;
      $display("FAIL R1 reset state: actual=%b expected=000000",
               {reset_pulse, clamp_pulse, xfer_pulse, conv_start, busy, done});
    end
    rst_n = 1;
    @(negedge clk);
    total++;
    if ({reset_pulse, clamp_pulse, xfer_pulse, conv_start, busy, done} != 0) begin
      bad++;
      $display("FAIL R1 idle after reset: actual=%b expected=000000",
               {reset_pulse, clamp_pulse, xfer_pulse, conv_start, busy, done});
    end
    for (int n = 0; n <= 3; n++)
      for (int val = 0; val <= 3; val++) begin
        run(n, val, 2, 2, 2, 2, 2);
        run(n, 2, val, 2, 2, 2, 2);
        run(n, 2, 2, val, 2, 2, 2);
        run(n, 2, 2, 2, val, 2, 2);
        run(n, 2, 2, 2, 2, val, 2);
        run(n, 2, 2, 2, 2, 2, val);
      end
    s = 5;
    for (int i = 0; i < 40; i++) begin
      s = (s * 37 + 11) % 4096;
      run(s % 4, (s / 4) % 4, (s / 16) % 5, (s / 80) % 3, (s / 240) % 4, (s / 7) % 4, (s / 13) % 6);
    end
    run(1, 0, 0, 0, 0, 0, 0);
    run(2, 1, 1, 1, 1, 1, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule